// File: doc/BRIEF.md
# Hysteresis Time Comparator for a Time-Domain Thermostat

This block makes the final decision of a time-domain thermostat. A conversion begins with a start pulse. Three single-cycle edge events then arrive on the clock: a temperature-dependent edge, a set-point edge and reference oscillator ticks. From the set-point edge and a programmable number of reference ticks, the block builds a delayed copy of the set-point edge. That copy marks the far end of a decision window.

The block records whether the temperature edge came after the set-point edge and whether it came after the delayed copy. Once all three edges have occurred, it updates a registered alarm. The alarm asserts or clears when the temperature edge lies outside the window. It holds its previous value when the temperature edge lies inside the window. This gives the alarm a hysteresis band that prevents chattering near the trip point.

A mode input selects protection against over-temperature or against under-temperature. Under-temperature mode inverts the sense of the alarm.

Top module: `hyst_time_cmp`

## Requirements
- R1: While `rst_n` is low at a clock edge, `alarm` is 0 after that edge.
- R2: In over-temperature mode (`under_mode`=0), a temperature edge that comes strictly after the delayed edge sets `alarm` to 1.
- R3: In over-temperature mode, a temperature edge that comes strictly before the set-point edge sets `alarm` to 0.
- R4: A temperature edge that comes strictly after the set-point edge, and on or before the delayed edge, leaves `alarm` unchanged in both modes.
- R5: The delayed edge falls in the cycle of the `hyst_code`-th `ref_tick` counted strictly after the set-point edge's cycle. With `hyst_code`=0 it falls in the set-point edge's own cycle, so the window closes and the block acts as a plain lead/lag comparator.
- R6: A temperature edge in the same cycle as another edge counts as arriving first, not late.
- R7: In under-temperature mode (`under_mode`=1), an early temperature edge (before the set-point edge) sets `alarm` to 1, and a late one (after the delayed edge) sets it to 0.
- R8: `alarm` changes only at the clock edge that ends the cycle in which the last of the three edges (temperature, set-point, delayed) occurs. `conv_start` begins a new conversion.
- R9: Within a conversion, only the first temperature edge and the first set-point edge count. Edge events in the `conv_start` cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Pulse that clears the capture state and begins a conversion |
| td_evt | input | 1 | Temperature-dependent edge event (single-cycle pulse) |
| ta_evt | input | 1 | Set-point edge event (single-cycle pulse) |
| ref_tick | input | 1 | Reference oscillator tick, one pulse per period |
| hyst_code | input | CODE_W (5) | Window width in reference ticks; sampled at the set-point edge |
| under_mode | input | 1 | 0 = over-temperature alarm, 1 = under-temperature alarm |
| alarm | output | 1 | Registered thermostat alarm |

## Verification
The bench places the temperature edge at the window boundaries. It uses the cycle of the set-point edge, the cycle of the delayed edge and one cycle past it. A design that mistreats coincident edges would flip the alarm where it should hold or clear. The bench also uses hysteresis codes 0 and 31. A counter that is off by one tick or overflows at the largest code would move the window and give the wrong alarm at those edges. Further cases check that the alarm does not change before the last edge arrives, that a stray event in the start cycle or a repeated event is ignored, and that under-temperature mode inverts the result while keeping the hold band.

// File: rtl/hyst_cmp_pkg.sv
// Shared types for the hysteresis time comparator.
// Assumes: no more than the protection-mode encoding needs sharing.
package hyst_cmp_pkg;
    typedef enum logic {
        PROT_OVER  = 1'b0,
        PROT_UNDER = 1'b1
    } prot_mode_t;
endpackage

// File: rtl/hyst_shift_gen.sv
// Delayed set-point edge generator.
// Arms on the first set-point edge, latches the code, and counts reference
// ticks strictly after that cycle. It fires on the code-th tick, or at once
// when the code is zero. Assumes single-cycle tick and event pulses.
module hyst_shift_gen #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ta_first,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              shift_now
);
    localparam int CNT_W = CODE_W + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic              armed;
    logic [CODE_W-1:0] cnt;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_next;
    logic              hit;

    // Next count and terminal-tick detection
    always_comb begin
        cnt_next  = {1'b0, cnt} + ONE;
        hit       = armed && tick && (cnt_next == {1'b0, code_q});
        shift_now = !clear && ((ta_first && (code == '0)) || hit);
    end

    // Arm, count and disarm the tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            armed  <= 1'b0;
            cnt    <= '0;
            code_q <= '0;
        end else if (ta_first && (code != '0)) begin
            armed  <= 1'b1;
            cnt    <= '0;
            code_q <= code;
        end else if (armed && tick) begin
            if (hit) armed <= 1'b0;
            else     cnt   <= cnt_next[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/edge_order_cap.sv
// Edge order capture.
// Keeps one flag per edge kind. When the temperature edge arrives, it samples
// whether the set-point edge and the delayed edge had been seen in earlier
// cycles, so an edge in the same cycle counts as later. It issues one decide
// pulse, in the cycle where the last of the three edges occurs.
module edge_order_cap (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic td_evt,
    input  logic ta_evt,
    input  logic shift_now,
    output logic ta_first,
    output logic decide,
    output logic late_a,
    output logic late_s
);
    logic ta_seen, sh_seen, td_seen, done;
    logic late_a_q, late_s_q;
    logic td_first;

    // First-occurrence detection, order sample and completion
    always_comb begin
        ta_first = ta_evt && !ta_seen && !clear;
        td_first = td_evt && !td_seen && !clear;
        late_a   = td_first ? ta_seen : late_a_q;
        late_s   = td_first ? sh_seen : late_s_q;
        decide   = !done && !clear
                   && (ta_seen || ta_first)
                   && (sh_seen || shift_now)
                   && (td_seen || td_first);
    end

    // Seen flags and the stored order sample
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ta_seen  <= 1'b0;
            sh_seen  <= 1'b0;
            td_seen  <= 1'b0;
            done     <= 1'b0;
            late_a_q <= 1'b0;
            late_s_q <= 1'b0;
        end else begin
            if (ta_first)  ta_seen <= 1'b1;
            if (shift_now) sh_seen <= 1'b1;
            if (td_first) begin
                td_seen  <= 1'b1;
                late_a_q <= ta_seen;
                late_s_q <= sh_seen;
            end
            if (decide) done <= 1'b1;
        end
    end
endmodule

// File: rtl/alarm_window.sv
// Alarm register with a hold window.
// On a decide pulse it sets, clears or keeps the alarm, depending on where
// the temperature edge fell relative to the window and on the protection mode.
module alarm_window
    import hyst_cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       decide,
    input  logic       late_a,
    input  logic       late_s,
    input  prot_mode_t mode,
    output logic       alarm
);
    logic nxt;

    // Window decision: outside the window moves the alarm, inside holds it
    always_comb begin
        nxt = alarm;
        if (decide) begin
            if (mode == PROT_OVER) begin
                if (late_s)      nxt = 1'b1;
                else if (!late_a) nxt = 1'b0;
            end else begin
                if (!late_a)     nxt = 1'b1;
                else if (late_s) nxt = 1'b0;
            end
        end
    end

    // Alarm state register
    always_ff @(posedge clk) begin
        if (!rst_n) alarm <= 1'b0;
        else        alarm <= nxt;
    end
endmodule

// File: rtl/hyst_time_cmp.sv
// Top level of the hysteresis time comparator.
// Ties together the delayed-edge generator, the order capture and the alarm
// register. All events are clock-synchronous single-cycle pulses.
module hyst_time_cmp
    import hyst_cmp_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              td_evt,
    input  logic              ta_evt,
    input  logic              ref_tick,
    input  logic [CODE_W-1:0] hyst_code,
    input  logic              under_mode,
    output logic              alarm
);
    logic ta_first, shift_now, decide, late_a, late_s;
    prot_mode_t mode;

    // Protection mode decode
    always_comb mode = under_mode ? PROT_UNDER : PROT_OVER;

    hyst_shift_gen #(.CODE_W(CODE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(conv_start), .ta_first(ta_first),
        .tick(ref_tick), .code(hyst_code), .shift_now(shift_now)
    );

    edge_order_cap u_cap (
        .clk(clk), .rst_n(rst_n), .clear(conv_start), .td_evt(td_evt),
        .ta_evt(ta_evt), .shift_now(shift_now), .ta_first(ta_first),
        .decide(decide), .late_a(late_a), .late_s(late_s)
    );

    alarm_window u_win (
        .clk(clk), .rst_n(rst_n), .decide(decide), .late_a(late_a),
        .late_s(late_s), .mode(mode), .alarm(alarm)
    );
endmodule

// File: rtl/hyst_time_cmp_chk.sv
// Property checker for the hysteresis time comparator, bound to the top.
module hyst_time_cmp_chk (
    input logic clk,
    input logic rst_n,
    input logic under_mode,
    input logic decide,
    input logic late_a,
    input logic late_s,
    input logic alarm
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !alarm); // R1
    AST_LATE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        decide && !under_mode && late_s |=> alarm); // R2
    AST_EARLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        decide && !under_mode && !late_a |=> !alarm); // R3
    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && decide && late_a && !late_s |=> $stable(alarm)); // R4
    AST_SHIFT_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> !(late_s && !late_a)); // R5
    AST_UNDER_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        decide && under_mode && !late_a |=> alarm); // R7
    AST_ONLY_ON_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !decide |=> $stable(alarm)); // R8
endmodule

bind hyst_time_cmp hyst_time_cmp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .under_mode(under_mode), .decide(decide),
    .late_a(late_a), .late_s(late_s), .alarm(alarm)
);

// File: tb/sim_hyst_time_cmp.sv
// Bench: walks a vector table of conversions, then directed corner tests.
// Ticks fall on odd cycles of a conversion (cycle 0 carries conv_start).
// With an even set-point cycle, the delayed edge is at ta + 2*code - 1.
module sim_hyst_time_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_start = 1'b0, td_evt = 1'b0, ta_evt = 1'b0, ref_tick = 1'b0;
    logic [4:0] hyst_code = '0;
    logic       under_mode = 1'b0;
    logic       alarm;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cycles = 0;

    always #2.5 clk = ~clk;

    hyst_time_cmp #(.CODE_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .td_evt(td_evt),
        .ta_evt(ta_evt), .ref_tick(ref_tick), .hyst_code(hyst_code),
        .under_mode(under_mode), .alarm(alarm)
    );

    // Vector: {under_mode, code, ta cycle, td cycle, expected alarm}
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 5'd4,  7'd4,  7'd2,  1'b0},
        {1'b0, 5'd4,  7'd4,  7'd20, 1'b1},
        {1'b0, 5'd4,  7'd4,  7'd8,  1'b1},
        {1'b0, 5'd4,  7'd4,  7'd4,  1'b0},
        {1'b0, 5'd4,  7'd4,  7'd8,  1'b0},
        {1'b0, 5'd4,  7'd4,  7'd11, 1'b0},
        {1'b0, 5'd4,  7'd4,  7'd12, 1'b1},
        {1'b0, 5'd0,  7'd6,  7'd6,  1'b0},
        {1'b0, 5'd0,  7'd6,  7'd7,  1'b1},
        {1'b0, 5'd31, 7'd4,  7'd2,  1'b0},
        {1'b0, 5'd31, 7'd4,  7'd64, 1'b0},
        {1'b0, 5'd31, 7'd4,  7'd66, 1'b1},
        {1'b1, 5'd3,  7'd4,  7'd2,  1'b1},
        {1'b1, 5'd3,  7'd4,  7'd9,  1'b1},
        {1'b1, 5'd3,  7'd4,  7'd10, 1'b0},
        {1'b1, 5'd3,  7'd4,  7'd6,  1'b0},
        {1'b1, 5'd3,  7'd10, 7'd4,  1'b1}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: alarm=%0b expected %0b", tag, act, exp);
        end
    endtask

    // One conversion of 70 cycles; optional mid-run check at cycle chk_k
    task automatic run_conv(input logic md, input logic [4:0] cd,
                            input int ta, input int td, input int td2,
                            input int chk_k, input logic chk_v, input string tag);
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            conv_start = (k == 0);
            ta_evt     = (k == ta);
            td_evt     = (k == td) || (k == td2);
            ref_tick   = (k % 2 == 1);
            hyst_code  = cd;
            under_mode = md;
            if (k == chk_k) check(tag, alarm, chk_v);
        end
        @(negedge clk);
        conv_start = 1'b0; ta_evt = 1'b0; td_evt = 1'b0; ref_tick = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: cycles=%0d expected <= 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", alarm, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic       md, ex;
            logic [4:0] cd;
            int         ta, td, sh;
            string      tag;
            md = VEC[i][20];
            cd = VEC[i][19:15];
            ta = int'(VEC[i][14:8]);
            td = int'(VEC[i][7:1]);
            ex = VEC[i][0];
            sh = (cd == 0) ? ta : ta + 2 * int'(cd) - 1;
            if (md)                         tag = "R7 under mode";
            else if (cd == 0 || cd == 31)   tag = "R5 shift code edge";
            else if (td == ta)              tag = "R6 coincident edges";
            else if (td > ta && td <= sh)   tag = "R4 window hold";
            else if (td > sh)               tag = "R2 late edge";
            else                            tag = "R3 early edge";
            run_conv(md, cd, ta, td, -1, -1, 1'b0, tag);
            check(tag, alarm, ex);
        end

        // R1: reset mid-state clears the alarm
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset after use", alarm, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: alarm still 0 before the last edge (td at 10), 1 after it
        run_conv(1'b0, 5'd2, 4, 10, -1, 10, 1'b0, "R8 before last edge");
        check("R8 after last edge", alarm, 1'b1);

        // R9: td in the start cycle is ignored, later repeat td is ignored
        run_conv(1'b0, 5'd2, 4, 0, 6, -1, 1'b0, "R9");
        check("R9 ignored events", alarm, 1'b1);
        run_conv(1'b0, 5'd2, 4, 6, 12, -1, 1'b0, "R9");
        check("R9 repeat td ignored", alarm, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule